// File: doc/BRIEF.md
# Operand Specifier Decoder

This block turns one variable-length operand specifier, arriving a byte at a time, into decoded fields for a 32-bit processor with sixteen registers. The first byte of a specifier splits into a high nibble (the addressing mode) and a low nibble (a register number). The mode, whether that register is the program counter (register 15), and the operand size supplied by the opcode decoder together decide how many extension bytes follow. A mode-4 byte is an index prefix: it names an index register and is followed by a second byte that is the base specifier.

Bytes come in over a valid/ready handshake. When the last byte of a specifier has been taken, the decoder raises a one-cycle completion pulse and presents the base mode, base register, the index flag and index register, the assembled extension value (short literal, sign-extended displacement, immediate or absolute address) and the total number of bytes the specifier used. An index prefix followed by a base that cannot be indexed ends the specifier at once with an illegal flag. The decoder then returns to wait for the next specifier. Memory accesses, register-file side effects and opcode decoding are the job of the neighbouring blocks.

Top module: `opspec_decoder`

## Requirements
- R1: A base byte with bits [7:6] = 00 is a short literal: no extension bytes follow, `spec_ext` equals bits [5:0] zero-extended, and an unindexed literal has `spec_len` = 1.
- R2: Base modes 5, 6 and 7 with any register, and modes 8 and 9 with a register other than 15, take no extension bytes and give `spec_ext` = 0.
- R3: Modes A and B take 1 extension byte, C and D take 2, E and F take 4 (any register); the bytes arrive least significant first and `spec_ext` holds the value sign-extended to 32 bits, with bits [63:32] zero.
- R4: Base byte 0x8F is an immediate whose length is set by `op_size` sampled with the base byte: code 0, 1, 2, 3 gives 1, 2, 4, 8 bytes; `spec_ext` holds the bytes least significant first, zero-extended.
- R5: Base byte 0x9F is an absolute address: 4 bytes follow, least significant first, and `spec_ext` holds them zero-extended.
- R6: A first byte with mode 4 is an index prefix: `spec_indexed` = 1, `spec_xreg` = its low nibble, the base byte follows it, and `spec_len` counts the prefix; otherwise `spec_indexed` = 0 and `spec_xreg` = 0.
- R7: An index prefix followed by a short literal, a mode-5 byte, byte 0x8F or another mode-4 byte sets `spec_illegal`; the specifier ends at that byte with `spec_len` = 2 and `spec_ext` = 0, the offending byte's nibbles in `spec_mode` and `spec_reg`.
- R8: A byte is taken only in a cycle with `in_valid` and `in_ready` both high; cycles without `in_valid` leave the decode unchanged whatever `in_byte` holds; `in_ready` is low only in the completion cycle.
- R9: `spec_done` is high for exactly one cycle, the cycle after the last byte of the specifier is taken, with all result fields valid in it and `spec_len` equal to the number of bytes taken.
- R10: After reset `in_ready` = 1 and `spec_done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_byte | input | 8 | Next specifier byte |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| op_size | input | 2 | Operand size code from the opcode decoder (0..3 = 1, 2, 4, 8 bytes) |
| spec_done | output | 1 | One-cycle completion pulse |
| spec_mode | output | 4 | Base byte high nibble |
| spec_reg | output | 4 | Base byte low nibble |
| spec_indexed | output | 1 | An index prefix was present |
| spec_xreg | output | 4 | Index register number |
| spec_ext | output | 64 | Literal, displacement, immediate or absolute value |
| spec_len | output | 4 | Bytes used by the specifier |
| spec_illegal | output | 1 | Forbidden base after an index prefix |

## Verification
The assertions watch, on every cycle, that completion is a single pulse that follows a taken byte, that a stalled decoder holds its progress, that illegal results carry the prefix, a length of two and a zero value, that literals report length one, and that displacements show a clean sign extension. Only the bench's scenarios can show that each mode consumes the right number of bytes, that the bytes are assembled in the right order, that the operand size picks the immediate length, and that garbage offered with `in_valid` low is ignored; it does this with random specifiers of every class, random stall gaps and directed sign and length corners.

// File: rtl/opspec_pkg.sv
package opspec_pkg;

  localparam int BYTE_W    = 8;
  localparam int EXT_LANES = 8;
  localparam int EXT_W     = BYTE_W * EXT_LANES;
  localparam int DISP_W    = 32;
  localparam int LEN_W     = 4;
  localparam int NIB_W     = 4;
  localparam int LIT_W     = 6;

  localparam logic [NIB_W-1:0] PC_REG     = 4'hF;
  localparam logic [NIB_W-1:0] MODE_INDEX = 4'h4;
  localparam logic [NIB_W-1:0] MODE_REG   = 4'h5;
  localparam logic [NIB_W-1:0] MODE_AINC  = 4'h8;
  localparam logic [NIB_W-1:0] MODE_AINCD = 4'h9;

  typedef enum logic [1:0] {EXT_NONE, EXT_LIT, EXT_DISP, EXT_RAW} ext_kind_e;
  typedef enum logic [1:0] {ST_HEAD, ST_BASE, ST_EXT, ST_DONE} dec_state_e;

  // operand size code to byte count
  function automatic logic [LEN_W-1:0] imm_bytes(input logic [1:0] code);
    return LEN_W'(1) << code;
  endfunction

  // final shaping of the collected extension
  function automatic logic [EXT_W-1:0] shape_ext(input ext_kind_e kind,
                                                 input logic [EXT_W-1:0] acc,
                                                 input logic [LIT_W-1:0] lit,
                                                 input logic [LEN_W-1:0] nbytes);
    logic [DISP_W-1:0] d;
    case (kind)
      EXT_LIT:  return {{(EXT_W-LIT_W){1'b0}}, lit};
      EXT_DISP: begin
        case (nbytes)
          4'd1:    d = {{(DISP_W-8){acc[7]}}, acc[7:0]};
          4'd2:    d = {{(DISP_W-16){acc[15]}}, acc[15:0]};
          default: d = acc[DISP_W-1:0];
        endcase
        return {{(EXT_W-DISP_W){1'b0}}, d};
      end
      EXT_RAW:  return acc;
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/opspec_classify.sv
module opspec_classify
  import opspec_pkg::*;
(
  input  logic [BYTE_W-1:0] spec_byte,
  input  logic [1:0]        size_code,
  output ext_kind_e         kind,
  output logic [LEN_W-1:0]  ext_len,
  output logic              is_index,
  output logic              bad_after_index
);
  logic [NIB_W-1:0] mode;
  logic             is_lit;
  logic             is_pc;

  assign mode   = spec_byte[7:4];
  assign is_lit = (spec_byte[7:6] == 2'b00);
  assign is_pc  = (spec_byte[3:0] == PC_REG);

  always_comb begin
    kind    = EXT_NONE;
    ext_len = '0;
    if (is_lit) begin
      kind = EXT_LIT;
    end else begin
      case (mode)
        MODE_AINC:  if (is_pc) begin kind = EXT_RAW; ext_len = imm_bytes(size_code); end
        MODE_AINCD: if (is_pc) begin kind = EXT_RAW; ext_len = 4'd4; end
        4'hA, 4'hB: begin kind = EXT_DISP; ext_len = 4'd1; end
        4'hC, 4'hD: begin kind = EXT_DISP; ext_len = 4'd2; end
        4'hE, 4'hF: begin kind = EXT_DISP; ext_len = 4'd4; end
        default: ;
      endcase
    end
  end

  assign is_index        = (mode == MODE_INDEX);
  assign bad_after_index = is_lit || (mode == MODE_REG) || (mode == MODE_INDEX) ||
                           ((mode == MODE_AINC) && is_pc);
endmodule

// File: rtl/opspec_collect.sv
module opspec_collect
  import opspec_pkg::*;
#(
  parameter int LANES = EXT_LANES,
  parameter int BW    = BYTE_W,
  parameter int CNT_W = $clog2(LANES + 1)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                load,
  input  logic [CNT_W-1:0]    lane_sel,
  input  logic [BW-1:0]       din,
  output logic [LANES*BW-1:0] acc
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                                  acc[g*BW +: BW] <= '0;
      else if (clear)                              acc[g*BW +: BW] <= '0;
      else if (load && (lane_sel == CNT_W'(g)))    acc[g*BW +: BW] <= din;
    end
  end

  // extension bytes never land outside the lanes
  assert_lane_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (lane_sel < CNT_W'(LANES)));

  // a cleared lane file is zero the cycle after
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == '0));
endmodule

// File: rtl/opspec_decoder.sv
module opspec_decoder
  import opspec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  input  logic [1:0]        op_size,
  output logic              spec_done,
  output logic [3:0]        spec_mode,
  output logic [3:0]        spec_reg,
  output logic              spec_indexed,
  output logic [3:0]        spec_xreg,
  output logic [63:0]       spec_ext,
  output logic [3:0]        spec_len,
  output logic              spec_illegal
);
  localparam int CNT_W = $clog2(EXT_LANES + 1);

  dec_state_e         state_q;
  ext_kind_e          kind_q;
  logic [LEN_W-1:0]   len_q;
  logic [CNT_W-1:0]   ext_cnt_q;
  logic [LEN_W-1:0]   ext_total_q;
  logic [NIB_W-1:0]   mode_q, reg_q, xreg_q;
  logic [LIT_W-1:0]   lit_q;
  logic               idx_q, illegal_q;
  logic [EXT_W-1:0]   acc;

  ext_kind_e          c_kind;
  logic [LEN_W-1:0]   c_ext_len;
  logic               c_index, c_bad;

  // named internal events
  logic accept, take_base, base_bad, ext_last, ext_load, head_clear;

  opspec_classify u_class (
    .spec_byte       (in_byte),
    .size_code       (op_size),
    .kind            (c_kind),
    .ext_len         (c_ext_len),
    .is_index        (c_index),
    .bad_after_index (c_bad)
  );

  opspec_collect #(.LANES(EXT_LANES), .BW(BYTE_W), .CNT_W(CNT_W)) u_coll (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (head_clear),
    .load     (ext_load),
    .lane_sel (ext_cnt_q),
    .din      (in_byte),
    .acc      (acc)
  );

  assign in_ready   = (state_q != ST_DONE);
  assign accept     = in_valid && in_ready;
  assign head_clear = accept && (state_q == ST_HEAD);
  assign ext_load   = accept && (state_q == ST_EXT);
  assign take_base  = accept && (((state_q == ST_HEAD) && !c_index) || (state_q == ST_BASE));
  assign base_bad   = (state_q == ST_BASE) && c_bad;
  assign ext_last   = ext_load && ((LEN_W'(ext_cnt_q) + 4'd1) == ext_total_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_HEAD;
      kind_q      <= EXT_NONE;
      len_q       <= '0;
      ext_cnt_q   <= '0;
      ext_total_q <= '0;
      mode_q      <= '0;
      reg_q       <= '0;
      xreg_q      <= '0;
      lit_q       <= '0;
      idx_q       <= 1'b0;
      illegal_q   <= 1'b0;
    end else if (accept) begin
      unique case (state_q)
        ST_HEAD: begin
          len_q     <= 4'd1;
          ext_cnt_q <= '0;
          idx_q     <= c_index;
          xreg_q    <= c_index ? in_byte[3:0] : '0;
          if (c_index) state_q <= ST_BASE;
        end
        ST_BASE: len_q <= len_q + 4'd1;
        ST_EXT: begin
          len_q     <= len_q + 4'd1;
          ext_cnt_q <= ext_cnt_q + CNT_W'(1);
          if (ext_last) state_q <= ST_DONE;
        end
        default: ;
      endcase
      if (take_base) begin
        mode_q      <= in_byte[7:4];
        reg_q       <= in_byte[3:0];
        lit_q       <= in_byte[5:0];
        illegal_q   <= base_bad;
        kind_q      <= base_bad ? EXT_NONE : c_kind;
        ext_total_q <= base_bad ? '0 : c_ext_len;
        state_q     <= (base_bad || (c_ext_len == '0)) ? ST_DONE : ST_EXT;
      end
    end else if (state_q == ST_DONE) begin
      state_q <= ST_HEAD;
    end
  end

  assign spec_done    = (state_q == ST_DONE);
  assign spec_mode    = mode_q;
  assign spec_reg     = reg_q;
  assign spec_indexed = idx_q;
  assign spec_xreg    = xreg_q;
  assign spec_len     = len_q;
  assign spec_illegal = illegal_q;
  assign spec_ext     = shape_ext(kind_q, acc, lit_q, ext_total_q);

  // R9: completion is a single-cycle pulse that follows a taken byte
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spec_done |=> !spec_done);
  assert_done_follows_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spec_done) |-> $past(accept));

  // R8: no byte offered means no progress
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && (state_q != ST_DONE)) |=> ($stable(state_q) && $stable(len_q) && $stable(ext_cnt_q)));

  // R7: illegal results have a fixed shape
  assert_illegal_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_done && spec_illegal) |-> (spec_indexed && (spec_len == 4'd2) && (spec_ext == '0)));

  // R1: a legal literal is a single byte with a 6-bit value
  assert_literal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_done && !spec_illegal && (spec_mode[3:2] == 2'b00)) |->
      ((spec_len == 4'd1) && (spec_ext[63:6] == '0)));

  // R3: displacement results are clean 32-bit sign extensions
  assert_disp_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_done && !spec_illegal && (spec_mode >= 4'hA)) |->
      ((spec_ext[63:32] == '0) &&
       ((spec_mode >= 4'hE) || (spec_ext[31:16] == {16{spec_ext[15]}}))));

  // R6: a specifier never exceeds prefix, base and an 8-byte immediate
  assert_len_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spec_done |-> ((spec_len >= 4'd1) && (spec_len <= 4'd10)));
endmodule

// File: tb/sim_opspec_decoder.sv
`timescale 1ns/1ps
module sim_opspec_decoder;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_ready;
  logic [1:0]  op_size;
  logic        spec_done;
  logic [3:0]  spec_mode, spec_reg, spec_xreg, spec_len;
  logic        spec_indexed, spec_illegal;
  logic [63:0] spec_ext;

  always #(CLK_P/2) clk = ~clk;

  opspec_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .op_size(op_size), .spec_done(spec_done),
    .spec_mode(spec_mode), .spec_reg(spec_reg), .spec_indexed(spec_indexed),
    .spec_xreg(spec_xreg), .spec_ext(spec_ext), .spec_len(spec_len),
    .spec_illegal(spec_illegal)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [7:0]  sb [10];
  int          sn;
  logic [1:0]  e_osz;
  logic [3:0]  e_mode, e_reg, e_xreg, e_len;
  logic        e_idx, e_ill;
  logic [63:0] e_ext;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // build one specifier and its expected result from the requirements
  task automatic make_spec(input bit wi, input logic [3:0] xr, input logic [7:0] base,
                           input logic [1:0] osz, input bit use_fill, input logic [7:0] fill);
    int nb = 0;
    bit sext = 1'b0;
    logic [63:0] raw = '0;
    sn = 0;
    e_idx = wi; e_xreg = wi ? xr : 4'h0; e_osz = osz;
    if (wi) begin sb[sn] = {4'h4, xr}; sn++; end
    sb[sn] = base; sn++;
    e_mode = base[7:4]; e_reg = base[3:0]; e_ext = '0; e_ill = 1'b0;
    if (wi && (base[7:6] == 2'b00 || base[7:4] == 4'h5 || base[7:4] == 4'h4 || base == 8'h8F))
      e_ill = 1'b1;
    else if (base[7:6] == 2'b00) e_ext = 64'(base[5:0]);
    else if (base == 8'h8F)      nb = 1 << osz;
    else if (base == 8'h9F)      nb = 4;
    else if (base[7:4] >= 4'hA) begin
      nb = (base[7:4] >= 4'hE) ? 4 : ((base[7:4] >= 4'hC) ? 2 : 1);
      sext = 1'b1;
    end
    for (int k = 0; k < nb; k++) begin
      logic [7:0] b = use_fill ? fill : 8'($urandom);
      sb[sn] = b; sn++;
      raw = raw | (64'(b) << (8*k));
    end
    if (nb > 0) begin
      if (sext && raw[8*nb-1]) e_ext = (raw - (64'd1 << (8*nb))) & 64'hFFFF_FFFF;
      else                     e_ext = raw;
    end
    e_len = 4'(sn);
  endtask

  task automatic run_spec(input string tag);
    op_size = e_osz;
    for (int i = 0; i < sn; i++) begin
      int gaps = $urandom_range(0, 2);
      for (int g = 0; g < gaps; g++) begin
        @(negedge clk);
        chk(in_ready && !spec_done, "R8 stall keeps ready, no done", {in_ready, spec_done}, 2'b10);
        in_valid = 1'b0; in_byte = 8'($urandom);
      end
      @(negedge clk);
      chk(in_ready && !spec_done, "R9 no done before last byte", {in_ready, spec_done}, 2'b10);
      in_valid = 1'b1; in_byte = sb[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_byte = 8'($urandom);
    chk(spec_done, "R9 done after last byte", 64'(spec_done), 1);
    chk(!in_ready, "R8 ready low in done cycle", 64'(in_ready), 0);
    chk(spec_mode == e_mode && spec_reg == e_reg, {tag, " mode/reg"}, {spec_mode, spec_reg}, {e_mode, e_reg});
    chk(spec_indexed == e_idx && spec_xreg == e_xreg, "R6 index fields", {spec_indexed, spec_xreg}, {e_idx, e_xreg});
    chk(spec_ext == e_ext, {tag, " ext value"}, spec_ext, e_ext);
    chk(spec_len == e_len, "R9 length", 64'(spec_len), 64'(e_len));
    chk(spec_illegal == e_ill, "R7 illegal flag", 64'(spec_illegal), 64'(e_ill));
    @(negedge clk);
    chk(!spec_done && in_ready, "R9 done is one cycle", {spec_done, in_ready}, 2'b01);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; op_size = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !spec_done, "R10 reset state", {in_ready, spec_done}, 2'b10);

    // directed corners
    make_spec(0, 4'h0, 8'h3F, 2'd0, 0, 8'h00); run_spec("R1");
    make_spec(0, 4'h0, 8'h00, 2'd0, 0, 8'h00); run_spec("R1");
    make_spec(0, 4'h0, 8'h85, 2'd3, 0, 8'h00); run_spec("R2");
    make_spec(1, 4'h2, 8'h9E, 2'd0, 0, 8'h00); run_spec("R2");
    make_spec(0, 4'h0, 8'hA1, 2'd0, 1, 8'h80); run_spec("R3");
    make_spec(0, 4'h0, 8'hCF, 2'd0, 1, 8'hFF); run_spec("R3");
    make_spec(1, 4'h7, 8'hE3, 2'd0, 1, 8'h80); run_spec("R3");
    make_spec(0, 4'h0, 8'hB2, 2'd0, 1, 8'h7F); run_spec("R3");
    make_spec(0, 4'h0, 8'h8F, 2'd3, 1, 8'hAB); run_spec("R4");
    make_spec(0, 4'h0, 8'h8F, 2'd0, 1, 8'hC3); run_spec("R4");
    make_spec(0, 4'h0, 8'h9F, 2'd2, 1, 8'h12); run_spec("R5");
    make_spec(1, 4'hF, 8'h9F, 2'd1, 0, 8'h00); run_spec("R5");
    make_spec(1, 4'h3, 8'h12, 2'd0, 0, 8'h00); run_spec("R7");
    make_spec(1, 4'h3, 8'h55, 2'd0, 0, 8'h00); run_spec("R7");
    make_spec(1, 4'h3, 8'h47, 2'd0, 0, 8'h00); run_spec("R7");
    make_spec(1, 4'h3, 8'h8F, 2'd3, 0, 8'h00); run_spec("R7");

    // constrained random
    for (int t = 0; t < 400; t++) begin
      int cat = $urandom_range(0, 5);
      logic [3:0] m = 4'h5;
      logic [3:0] r = 4'($urandom);
      logic [3:0] x = 4'($urandom);
      logic [1:0] sz = 2'($urandom);
      bit wi = 1'b0;
      case (cat)
        0: begin make_spec(0, x, {2'b00, 6'($urandom)}, sz, 0, 8'h00); run_spec("R1"); end
        1: begin
          m = 4'($urandom_range(5, 9));
          if (m >= 4'h8 && r == 4'hF) r = 4'hE;
          wi = (m != 4'h5) && $urandom_range(0, 1) == 1;
          make_spec(wi, x, {m, r}, sz, 0, 8'h00); run_spec("R2");
        end
        2: begin
          m = 4'($urandom_range(10, 15));
          wi = $urandom_range(0, 1) == 1;
          make_spec(wi, x, {m, r}, sz, 0, 8'h00); run_spec("R3");
        end
        3: begin make_spec(0, x, 8'h8F, sz, 0, 8'h00); run_spec("R4"); end
        4: begin
          wi = $urandom_range(0, 1) == 1;
          make_spec(wi, x, 8'h9F, sz, 0, 8'h00); run_spec("R5");
        end
        default: begin
          case ($urandom_range(0, 3))
            0:       make_spec(1, x, {2'b00, 6'($urandom)}, sz, 0, 8'h00);
            1:       make_spec(1, x, {4'h5, r}, sz, 0, 8'h00);
            2:       make_spec(1, x, {4'h4, r}, sz, 0, 8'h00);
            default: make_spec(1, x, 8'h8F, sz, 0, 8'h00);
          endcase
          run_spec("R7");
        end
      endcase
    end
    summary();
  end
endmodule